// File: doc/BRIEF.md
# Framed Serial Word Receiver with Chain Output

This block is the digital write port of an eight-channel serial converter, modelled fully synchronously. An active-low frame strobe, a serial clock and a serial data line arrive from outside. All three pass through synchronizer chains into the system clock domain, and edges are found on the synchronized copies. While the strobe is low, each falling serial clock edge shifts one bit into a 16-bit register, most significant bit first. When the strobe returns high after at least sixteen such edges, the block emits a one-cycle valid pulse with the captured word. A shorter frame is dropped.

A chain output lets a second identical port sit behind this one. Once a frame has gone past sixteen edges, every further edge pushes the bit that leaves the top of the register onto the chain output. The downstream port sees the stream delayed by sixteen bits. The last sixteen bits of a long frame stay in the register, and those are what this port commits.

Top module: `dac_frame_port`

## Requirements
- R1: While frameN is low, each falling sclk edge shifts sdi into the register from the bottom, so the first bit of a 16-bit frame lands in wordOut[15] and the last in wordOut[0].
- R2: A rise of frameN after 16 or more counted falling sclk edges asserts wordValid with the captured word on wordOut, a few system clocks after the rise.
- R3: A rise of frameN after fewer than 16 counted edges, exactly 15 included, produces no wordValid pulse.
- R4: sdo stays 0 while 16 or fewer edges have been counted in the current frame.
- R5: From the 17th edge on, sdo carries the bit pushed out of wordOut's MSB position, which is the bit received sixteen edges earlier.
- R6: In a frame longer than 16 edges, the committed word is the last 16 bits received. The edge counter saturates at 17.
- R7: wordValid is high for exactly one system clock per commit, and wordOut keeps its value between commits.
- R8: A falling sclk edge that reaches the synchronized domain in the same cycle as the frameN rise is not counted.
- R9: After reset, wordValid, wordOut and sdo are all 0.
- R10: sclk edges while frameN is high are not counted. They cause no commit, leave sdo at 0, and do not carry over into the next frame's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than sclk |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial clock; data taken on falling edges |
| sdi | input | 1 | Serial data in |
| wordValid | output | 1 | One-cycle commit pulse |
| wordOut | output | 16 | Last committed word |
| sdo | output | 1 | Chain data to the next port's sdi |

## Verification
The collision that matters is a falling serial clock edge and the strobe rise that ends the frame arriving in the same system clock after synchronization. The counter must not take that edge, so a frame whose 16th edge coincides with the strobe rise must abort. The bench provokes this by driving sclk low and frameN high in the same instant after fifteen ordinary bits. Because both signals pass through identical synchronizer chains, they land together. The bench then judges the frame by confirming that no commit pulse appears and that the previous word is still on wordOut.

// File: rtl/dac_port_pkg.sv
package dac_port_pkg;
  // strobes from control to datapath, one system cycle each
  typedef struct packed {
    logic shift;   // take the synchronized data bit
    logic spill;   // capture the bit leaving the MSB
    logic clear;   // strobe idle: drop chain state
    logic commit;  // publish the shift register
    logic drive;   // chain output enabled
  } portStrobes_t;
endpackage

// File: rtl/dac_port_sync.sv
module dac_port_sync #(
  parameter int STAGES = 2,
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    if (STAGES == 1) begin : gOne
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[0] <= RST_VAL;
        else       stage[0] <= d;
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
          stage[0] <= d;
          for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dac_port_ctrl.sv
module dac_port_ctrl
  import dac_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             sclk,
  input  logic             sdi,
  output portStrobes_t     strobes,
  output logic             sdiBit,
  output logic [CNT_W-1:0] bitCount
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(WORD_W + 1);

  logic [2:0] syncQ;
  logic frameS, sclkS, frameQ, sclkQ;
  logic sclkFall, frameRise;

  dac_port_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) inSync (
    .clk(clk), .rstN(rstN), .d({frameN, sclk, sdi}), .q(syncQ)
  );

  assign frameS = syncQ[2];
  assign sclkS  = syncQ[1];
  assign sdiBit = syncQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= 1'b1;
      sclkQ  <= 1'b1;
    end else begin
      frameQ <= frameS;
      sclkQ  <= sclkS;
    end
  end

  // a fall only counts while the strobe is still low in this cycle
  assign sclkFall  = sclkQ & ~sclkS & ~frameS;
  assign frameRise = ~frameQ & frameS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         bitCount <= '0;
    else if (frameS)                   bitCount <= '0;
    else if (sclkFall && bitCount != SAT) bitCount <= bitCount + 1'b1;
  end

  always_comb begin
    strobes.shift  = sclkFall;
    strobes.spill  = sclkFall && (bitCount >= FULL);
    strobes.clear  = frameS;
    strobes.commit = frameRise && (bitCount >= FULL);
    strobes.drive  = (bitCount == SAT);
  end
endmodule

// File: rtl/dac_port_datapath.sv
module dac_port_datapath
  import dac_port_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strobes,
  input  logic              sdiBit,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordOut,
  output logic              sdo
);
  logic [WORD_W-1:0] shiftReg;
  logic spillBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strobes.shift) shiftReg <= {shiftReg[WORD_W-2:0], sdiBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              spillBit <= 1'b0;
    else if (strobes.clear) spillBit <= 1'b0;
    else if (strobes.spill) spillBit <= shiftReg[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordOut   <= '0;
    end else begin
      wordValid <= strobes.commit;
      if (strobes.commit) wordOut <= shiftReg;
    end
  end

  assign sdo = strobes.drive & spillBit;
endmodule

// File: rtl/dac_frame_port.sv
module dac_frame_port
  import dac_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordOut,
  output logic              sdo
);
  localparam int CNT_W = $clog2(WORD_W + 2);

  portStrobes_t strobes;
  logic sdiBit;
  logic [CNT_W-1:0] bitCount;

  dac_port_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .sclk(sclk), .sdi(sdi),
    .strobes(strobes), .sdiBit(sdiBit), .bitCount(bitCount)
  );

  dac_port_datapath #(.WORD_W(WORD_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdiBit(sdiBit),
    .wordValid(wordValid), .wordOut(wordOut), .sdo(sdo)
  );
endmodule

// File: rtl/dac_frame_port_chk.sv
module dac_frame_port_chk #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordOut,
  input logic              sdo,
  input logic [CNT_W-1:0]  bitCount
);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordOut));

  assert_sdo_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bitCount <= CNT_W'(WORD_W)) |-> !sdo);

  assert_count_sat_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(WORD_W + 1));

  assert_commit_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordValid) |-> ($past(bitCount) >= CNT_W'(WORD_W)));
endmodule

bind dac_frame_port dac_frame_port_chk #(.WORD_W(WORD_W)) chk (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordOut(wordOut),
  .sdo(sdo), .bitCount(bitCount)
);

// File: tb/dac_frame_port_test.sv
module dac_frame_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic wordValid, sdo;
  logic [15:0] wordOut;

  int tests = 0;
  int fails = 0;
  int commits = 0;
  int doubles = 0;
  logic prevValid = 1'b0;
  logic [15:0] lastWord = '0;

  always #5 clk = ~clk;

  dac_frame_port uut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .sclk(sclk), .sdi(sdi),
    .wordValid(wordValid), .wordOut(wordOut), .sdo(sdo)
  );

  // commit monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (wordValid) begin
      commits++;
      lastWord = wordOut;
      if (prevValid) doubles++;
    end
    prevValid = wordValid;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    sclk = 1'b1;
    wait_clk(6);
    sclk = 1'b0;
    wait_clk(6);
  endtask

  // full frame; sdo checked after every falling edge
  task automatic run_frame(input int nb, input logic [23:0] data);
    int c0;
    logic expSdo;
    c0 = commits;
    frameN = 1'b0;
    wait_clk(6);
    for (int k = 1; k <= nb; k++) begin
      send_bit(data[nb-k]);
      expSdo = (k > 16) ? data[nb-(k-16)] : 1'b0;
      check(sdo === expSdo, (k > 16) ? "R5 chain bit" : "R4 chain quiet",
            int'(sdo), int'(expSdo));
    end
    sclk = 1'b1;
    wait_clk(6);
    frameN = 1'b1;
    wait_clk(10);
    if (nb >= 16) begin
      check(commits - c0 == 1, "R2 commit count", commits - c0, 1);
      check(lastWord === data[15:0], (nb > 16) ? "R6 last 16 bits" : "R1 R2 word",
            int'(lastWord), int'(data[15:0]));
    end else begin
      check(commits == c0, "R3 abort", commits - c0, 0);
    end
  endtask

  localparam int NVEC = 6;
  localparam int VEC_NB [NVEC] = '{16, 15, 20, 8, 17, 16};
  localparam logic [23:0] VEC_DATA [NVEC] = '{
    24'h00A5C3, 24'h007FFF, 24'hF1B2D4, 24'h0000FF, 24'h01E00F, 24'h008001
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] held;
    int c0;
    wait_clk(3);
    check(wordValid === 1'b0, "R9 valid after reset", int'(wordValid), 0);
    check(wordOut === 16'h0, "R9 word after reset", int'(wordOut), 0);
    check(sdo === 1'b0, "R9 sdo after reset", int'(sdo), 0);
    rstN = 1'b1;
    wait_clk(5);

    for (int v = 0; v < NVEC; v++) run_frame(VEC_NB[v], VEC_DATA[v]);

    // R10: serial clock activity with the strobe idle
    c0 = commits;
    held = wordOut;
    for (int k = 0; k < 20; k++) begin
      send_bit(1'b1);
      check(sdo === 1'b0, "R10 sdo idle", int'(sdo), 0);
    end
    sclk = 1'b1;
    wait_clk(10);
    check(commits == c0, "R10 no commit idle", commits - c0, 0);
    run_frame(15, 24'h001234);
    check(wordOut === held, "R10 no carried count", int'(wordOut), int'(held));

    // R8: 16th fall lands together with the strobe rise
    c0 = commits;
    held = wordOut;
    frameN = 1'b0;
    wait_clk(6);
    for (int k = 0; k < 15; k++) send_bit(k[0]);
    sdi = 1'b1;
    sclk = 1'b1;
    wait_clk(6);
    sclk = 1'b0;
    frameN = 1'b1;
    wait_clk(12);
    check(commits == c0, "R8 coincident edge ignored", commits - c0, 0);
    check(wordOut === held, "R8 word held", int'(wordOut), int'(held));
    sclk = 1'b1;
    wait_clk(6);

    // a good frame right after still commits
    run_frame(16, 24'h00BEEF);
    check(doubles == 0, "R7 single pulse", doubles, 0);
    check(commits == 5, "R7 commit total", commits, 5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule